// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block is a direct-mapped cache of branch targets that the fetch stage consults with the PC it is about to fetch. When the PC hits, the stored target becomes the next fetch address. Fetch can then follow a taken branch before the branch has been decoded. When the PC misses, fetch steps to the next sequential word.

Having an entry is itself the taken prediction. Entries are created only for branches that resolved taken, and they are removed when a predicted-taken branch falls through.

Later in the pipeline, a resolve port reports each branch once. It gives the branch PC, the actual direction and target, and the prediction that fetch received for that branch (hit flag and predicted target). The block classifies that report, updates the table on the same clock edge, and in the following cycle raises a one-cycle flush with the correct restart PC whenever fetch went down the wrong path.

The resolve classifier is written as a state machine. Its register holds the outcome of the previous cycle's resolve, and each outcome is a named state:

- `RS_IDLE`: no resolve.
- `RS_MISS_OK`: missed and not taken.
- `RS_HIT_OK`: hit, taken, same target.
- `RS_ALLOC`: missed but taken. The entry is written.
- `RS_DROP`: hit but not taken. The entry is cleared.
- `RS_RETARGET`: hit and taken to a new target. The target is rewritten.

Every cycle, the machine moves from its current state to the state chosen by the current resolve input, or back to `RS_IDLE` when there is none. The flush output is raised in the states `RS_ALLOC`, `RS_DROP` and `RS_RETARGET`.

Top module: `fetch_target_buffer`

## Requirements
- R1: After reset, every entry is invalid, so no fetch PC hits and flush is low.
- R2: A fetch that misses drives pred_hit low and pred_next_pc to fetch_pc + 4.
- R3: A hit requires fetch_valid high, the entry at index fetch_pc[5:2] valid, and equality of the whole stored upper PC field fetch_pc[31:6]. On a hit, pred_next_pc is the stored target. A PC with the same index but a different upper field misses.
- R4: A resolve with was_hit low and taken high writes the entry. A later fetch of that PC hits with the reported target.
- R5: The taken-and-missed case of R4 raises flush in the cycle after the resolve, with restart_pc equal to the actual target.
- R6: A resolve with was_hit high and taken low clears the entry and raises flush in the next cycle, with restart_pc = branch PC + 4.
- R7: A resolve with was_hit high, taken high and the actual target equal to the predicted target raises no flush and leaves the entry unchanged.
- R8: A resolve with was_hit high, taken high and a different actual target rewrites the stored target and raises flush in the next cycle, with restart_pc equal to the new target.
- R9: A resolve with was_hit low and taken low raises no flush and creates no entry.
- R10: A lookup in the same cycle as a write to the same index sees the contents from before the write.
- R11: Flush is high only in the cycle right after a resolve of class R5, R6 or R8, and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch lookup is requested this cycle |
| fetch_pc | input | 32 | PC being fetched |
| pred_hit | output | 1 | Lookup hit (predicted taken) |
| pred_next_pc | output | 32 | Predicted next fetch PC |
| rsv_valid | input | 1 | A branch resolves this cycle |
| rsv_pc | input | 32 | Resolved branch PC |
| rsv_taken | input | 1 | Actual direction, 1 = taken |
| rsv_target | input | 32 | Actual taken target |
| rsv_was_hit | input | 1 | Fetch hit for this branch |
| rsv_pred_target | input | 32 | Target that fetch used on the hit |
| flush | output | 1 | Wrong path fetched, restart needed |
| restart_pc | output | 32 | Correct fetch PC when flush is high |

## Verification
The bench probes a PC that shares an index with a live entry but differs in its upper bits. A design comparing only part of the tag would report a false hit there. It also re-fetches the same PC after a retarget and after a fall-through. A design that failed to rewrite or clear the entry would keep steering fetch to the stale target.

A lookup is placed in the same cycle as an allocation to its own index. A write-through design would hit one cycle early.

Flush is checked both in the cycle after a resolve and in the cycle after that. A design that was off by one cycle, or that held flush for more than one cycle, would miscompare.

// File: rtl/ftb_pkg.sv
package ftb_pkg;
    typedef enum logic [2:0] {
        RS_IDLE,
        RS_MISS_OK,
        RS_HIT_OK,
        RS_ALLOC,
        RS_DROP,
        RS_RETARGET
    } rs_state_t;
endpackage

// File: rtl/ftb_store.sv
module ftb_store #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16,
    parameter int ALIGN   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_next,
    input  logic            wr_en,
    input  logic            wr_set,
    input  logic [PC_W-1:0] wr_pc,
    input  logic [PC_W-1:0] wr_target
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - ALIGN;
    localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [PC_W-1:0]    tgt_q [ENTRIES];

    logic [IDX_W-1:0] lk_idx, wr_idx;
    logic [TAG_W-1:0] lk_tag, wr_tag;

    assign lk_idx = lk_pc[ALIGN +: IDX_W];
    assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
    assign wr_idx = wr_pc[ALIGN +: IDX_W];
    assign wr_tag = wr_pc[PC_W-1 -: TAG_W];

    // Read from the registers: a write on this edge is not visible yet.
    always_comb begin
        lk_hit  = lk_valid && valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_next = lk_hit ? tgt_q[lk_idx] : lk_pc + STEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_set;
            if (wr_set) begin
                tag_q[wr_idx] <= wr_tag;
                tgt_q[wr_idx] <= wr_target;
            end
        end
    end

    assert_alloc_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_set) |=> valid_q[$past(wr_idx)]);

    assert_entry_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_set) |=> !valid_q[$past(wr_idx)]);
endmodule

// File: rtl/ftb_classify.sv
module ftb_classify
    import ftb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int ALIGN = 2
) (
    input  logic            rsv_valid,
    input  logic [PC_W-1:0] rsv_pc,
    input  logic            rsv_taken,
    input  logic [PC_W-1:0] rsv_target,
    input  logic            rsv_was_hit,
    input  logic [PC_W-1:0] rsv_pred_target,
    output rs_state_t       outcome,
    output logic [PC_W-1:0] restart
);
    localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN;

    always_comb begin
        outcome = RS_IDLE;
        restart = rsv_target;
        if (rsv_valid) begin
            unique case ({rsv_was_hit, rsv_taken})
                2'b00: outcome = RS_MISS_OK;
                2'b01: outcome = RS_ALLOC;
                2'b10: begin
                    outcome = RS_DROP;
                    restart = rsv_pc + STEP;
                end
                2'b11: outcome = (rsv_target == rsv_pred_target) ? RS_HIT_OK : RS_RETARGET;
            endcase
        end
    end
endmodule

// File: rtl/ftb_ctrl.sv
module ftb_ctrl
    import ftb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  rs_state_t       outcome,
    input  logic [PC_W-1:0] restart_in,
    output logic            wr_en,
    output logic            wr_set,
    output logic            flush,
    output logic [PC_W-1:0] restart_pc
);
    rs_state_t       state_q;
    logic [PC_W-1:0] restart_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RS_IDLE;
            restart_q <= '0;
        end else begin
            state_q   <= outcome;
            restart_q <= restart_in;
        end
    end

    always_comb begin
        unique case (state_q)
            RS_ALLOC, RS_DROP, RS_RETARGET: flush = 1'b1;
            default:                        flush = 1'b0;
        endcase
        restart_pc = restart_q;
    end

    always_comb begin
        wr_en  = 1'b0;
        wr_set = 1'b0;
        unique case (outcome)
            RS_ALLOC, RS_RETARGET: begin
                wr_en  = 1'b1;
                wr_set = 1'b1;
            end
            RS_DROP: wr_en = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/fetch_target_buffer.sv
module fetch_target_buffer
    import ftb_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16,
    parameter int ALIGN   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            rsv_valid,
    input  logic [PC_W-1:0] rsv_pc,
    input  logic            rsv_taken,
    input  logic [PC_W-1:0] rsv_target,
    input  logic            rsv_was_hit,
    input  logic [PC_W-1:0] rsv_pred_target,
    output logic            flush,
    output logic [PC_W-1:0] restart_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN;

    rs_state_t       outcome;
    logic [PC_W-1:0] restart_c;
    logic            wr_en, wr_set;

    ftb_store #(.PC_W(PC_W), .ENTRIES(ENTRIES), .ALIGN(ALIGN)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (fetch_valid),
        .lk_pc     (fetch_pc),
        .lk_hit    (pred_hit),
        .lk_next   (pred_next_pc),
        .wr_en     (wr_en),
        .wr_set    (wr_set),
        .wr_pc     (rsv_pc),
        .wr_target (rsv_target)
    );

    ftb_classify #(.PC_W(PC_W), .ALIGN(ALIGN)) u_classify (
        .rsv_valid       (rsv_valid),
        .rsv_pc          (rsv_pc),
        .rsv_taken       (rsv_taken),
        .rsv_target      (rsv_target),
        .rsv_was_hit     (rsv_was_hit),
        .rsv_pred_target (rsv_pred_target),
        .outcome         (outcome),
        .restart         (restart_c)
    );

    ftb_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .outcome    (outcome),
        .restart_in (restart_c),
        .wr_en      (wr_en),
        .wr_set     (wr_set),
        .flush      (flush),
        .restart_pc (restart_pc)
    );

    assert_miss_sequential_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !pred_hit) |-> (pred_next_pc == fetch_pc + STEP));

    assert_hit_needs_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> fetch_valid);

    assert_drop_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_valid && rsv_was_hit && !rsv_taken) |=>
            (flush && restart_pc == $past(rsv_pc) + STEP));

    assert_hit_ok_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_valid && rsv_was_hit && rsv_taken && rsv_target == rsv_pred_target) |=> !flush);

    assert_flush_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> $past(rsv_valid));
endmodule

// File: tb/fetch_target_buffer_bench.sv
module fetch_target_buffer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit;
    logic [31:0] pred_next_pc;
    logic        rsv_valid = 1'b0;
    logic [31:0] rsv_pc = '0;
    logic        rsv_taken = 1'b0;
    logic [31:0] rsv_target = '0;
    logic        rsv_was_hit = 1'b0;
    logic [31:0] rsv_pred_target = '0;
    logic        flush;
    logic [31:0] restart_pc;

    always #10 clk = ~clk;

    fetch_target_buffer u_fetch_target_buffer (
        .clk, .rst_n, .fetch_valid, .fetch_pc, .pred_hit, .pred_next_pc,
        .rsv_valid, .rsv_pc, .rsv_taken, .rsv_target, .rsv_was_hit,
        .rsv_pred_target, .flush, .restart_pc
    );

    typedef struct {
        bit          is_flush;
        bit          exp_bit;
        logic [31:0] exp_pc;
        string       req;
    } item_t;

    item_t q[$];
    event  mon_ev;
    int    n_checks = 0;
    int    n_fail = 0;

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            @(mon_ev);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_checks++;
                if (it.is_flush) begin
                    if (flush !== it.exp_bit || (it.exp_bit && restart_pc !== it.exp_pc)) begin
                        n_fail++;
                        $display("FAIL %s: flush=%0b restart=%h, expected flush=%0b restart=%h",
                                 it.req, flush, restart_pc, it.exp_bit, it.exp_pc);
                    end
                end else begin
                    if (pred_hit !== it.exp_bit || pred_next_pc !== it.exp_pc) begin
                        n_fail++;
                        $display("FAIL %s: hit=%0b next=%h, expected hit=%0b next=%h",
                                 it.req, pred_hit, pred_next_pc, it.exp_bit, it.exp_pc);
                    end
                end
            end
        end
    end

    task automatic push(bit f, bit b, logic [31:0] pc, string req);
        item_t it;
        it.is_flush = f; it.exp_bit = b; it.exp_pc = pc; it.req = req;
        q.push_back(it);
        -> mon_ev;
    endtask

    task automatic do_fetch(logic [31:0] pc, bit v, bit eh, logic [31:0] en, string req);
        @(negedge clk);
        fetch_valid = v; fetch_pc = pc;
        #1;
        push(1'b0, eh, en, req);
    endtask

    task automatic do_resolve(logic [31:0] pc, bit tk, logic [31:0] tgt, bit wh,
                              logic [31:0] ptgt, bit ef, logic [31:0] er, string req);
        @(negedge clk);
        fetch_valid = 1'b0;
        rsv_valid = 1'b1; rsv_pc = pc; rsv_taken = tk; rsv_target = tgt;
        rsv_was_hit = wh; rsv_pred_target = ptgt;
        @(negedge clk);
        push(1'b1, ef, er, req);
        rsv_valid = 1'b0;
    endtask

    task automatic idle_check(string req);
        @(negedge clk);
        fetch_valid = 1'b0;
        push(1'b1, 1'b0, 32'h0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_check("R1 flush low after reset");
        do_fetch(32'h100, 1, 0, 32'h104, "R1 no hit after reset");
        do_fetch(32'h3C0, 1, 0, 32'h3C4, "R2 miss goes sequential");
        // R5 allocate on taken miss
        do_resolve(32'h100, 1, 32'h400, 0, 32'h0, 1, 32'h400, "R5 flush to target on taken miss");
        idle_check("R11 flush lasts one cycle");
        do_fetch(32'h100, 1, 1, 32'h400, "R4 allocated entry hits");
        do_fetch(32'h100, 0, 0, 32'h104, "R3 no hit without fetch_valid");
        do_fetch(32'h140, 1, 0, 32'h144, "R3 same index other tag misses");
        // R7 correct taken hit
        do_resolve(32'h100, 1, 32'h400, 1, 32'h400, 0, 32'h0, "R7 correct hit no flush");
        do_fetch(32'h100, 1, 1, 32'h400, "R7 entry kept");
        // R8 retarget
        do_resolve(32'h100, 1, 32'h480, 1, 32'h400, 1, 32'h480, "R8 flush to new target");
        do_fetch(32'h100, 1, 1, 32'h480, "R8 target rewritten");
        // R6 fall-through
        do_resolve(32'h100, 0, 32'h480, 1, 32'h480, 1, 32'h104, "R6 flush to pc+4");
        idle_check("R11 no flush after pulse");
        do_fetch(32'h100, 1, 0, 32'h104, "R6 entry removed");
        // R9 not-taken miss
        do_resolve(32'h208, 0, 32'h900, 0, 32'h0, 0, 32'h0, "R9 no flush");
        do_fetch(32'h208, 1, 0, 32'h20C, "R9 no entry created");
        // R10 same-cycle lookup and allocation
        @(negedge clk);
        rsv_valid = 1'b1; rsv_pc = 32'h30C; rsv_taken = 1'b1; rsv_target = 32'h800;
        rsv_was_hit = 1'b0; rsv_pred_target = 32'h0;
        fetch_valid = 1'b1; fetch_pc = 32'h30C;
        #1;
        push(1'b0, 1'b0, 32'h310, "R10 lookup sees pre-write contents");
        @(negedge clk);
        push(1'b1, 1'b1, 32'h800, "R5 flush after simultaneous alloc");
        rsv_valid = 1'b0;
        #1;
        push(1'b0, 1'b1, 32'h800, "R10 write visible next cycle");
        // second entry leaves the first untouched
        do_resolve(32'h104, 1, 32'h900, 0, 32'h0, 1, 32'h900, "R5 alloc second index");
        do_fetch(32'h104, 1, 1, 32'h900, "R4 second entry hits");
        do_fetch(32'h30C, 1, 1, 32'h800, "R4 other entry intact");
        idle_check("R11 idle no flush");
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule